// File: doc/BRIEF.md
# Burst Write Strobe Generator

This block turns one incrementing burst command into a stream of per-beat write descriptors. A command carries a 32-bit start address, a transfer size code and a length field. The block accepts the command with a valid/ready handshake. It then presents one beat per cycle under its own valid/ready pair. Each beat carries the beat address, the byte-lane write strobe for the data bus and a flag that marks the final beat.

The strobe is derived separately for each beat. It uses the beat's own address, which need not be aligned, together with the beat width. Lanes start at the beat address's position within the bus word and run upward for the beat width. Any lanes that would fall past the top lane of the bus are dropped.

The bus width is a parameter, 64 bits by default, which gives 8 strobe lanes. A new command is taken only while no burst is in flight.

Top module: `burst_strobe_gen`

## Requirements
- R1: While reset is active and right after it, `beat_valid` is 0 and `cmd_ready` is 1.
- R2: `cmd_ready` is 1 only when no burst is in progress. A `cmd_valid` raised during a burst has no effect on that burst's beats. `cmd_ready` and `beat_valid` are never 1 together.
- R3: A command with length field L produces exactly L+1 beats. `beat_last` is 1 on the final beat only, and the block is idle with `cmd_ready` at 1 in the cycle after that beat's handshake.
- R4: Beat k (k counted from 0) has address start + (k << S) modulo 2^32, where S is the effective size code.
- R5: The strobe sets lane i (bit i of `beat_strb`) exactly when o <= i < o + 2^S. Here o is the beat address modulo the number of bus bytes. Lanes at or above the bus byte count are dropped. For example, on the 8-lane bus, address 3 with size code 2 gives 0x78, and address 7 with size code 2 gives 0x80.
- R6: A size code greater than log2 of the bus byte count is treated as that maximum (code 3 on the default bus, i.e. 8 bytes per beat). This applies to both address stepping and the strobe.
- R7: While `beat_valid` is 1 and `beat_ready` is 0, the beat address, strobe and last flag hold their values and `beat_valid` stays 1.
- R8: Address stepping wraps silently past 0xFFFFFFFF.
- R9: The first beat is presented with `beat_valid` at 1 in the cycle after the command handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_addr | input | ADDR_W (32) | Burst start address |
| cmd_size | input | SIZE_W (3) | Size code; bytes per beat is 2^code |
| cmd_len | input | LEN_W (8) | Beat count minus one |
| beat_valid | output | 1 | Beat descriptor present |
| beat_ready | input | 1 | Beat descriptor consumed |
| beat_addr | output | ADDR_W (32) | Address of the current beat |
| beat_strb | output | DATA_W/8 (8) | Byte-lane write strobe of the current beat |
| beat_last | output | 1 | Current beat is the final one |

## Verification
The checker assumes the beat consumer may stall at any time, and that commands may be offered while a burst runs. It makes no assumption about alignment or size codes, so every address offset and every size code, including codes above the clamp, is legal input. The bench sweeps all eight lane offsets against all eight size codes and four lengths. It inserts consumer stalls and commands offered during a busy burst on a regular subset of these cases, and it runs a burst that straddles the top of the address space.

// File: rtl/bstrb_pkg.sv
package bstrb_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_BEAT = 1'b1
   } seq_state_e;
endpackage

// File: rtl/bstrb_sequencer.sv
module bstrb_sequencer
   import bstrb_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int LEN_W    = 8,
   parameter int SIZE_W   = 3,
   parameter int MAX_SIZE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [SIZE_W-1:0] cmd_size,
   input  logic [LEN_W-1:0]  cmd_len,
   output logic              cmd_ready,
   input  logic              beat_ready,
   output logic              beat_valid,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [SIZE_W-1:0] cur_size,
   output logic              is_last
);
   localparam logic [SIZE_W-1:0] SIZE_CAP = SIZE_W'(MAX_SIZE);

   seq_state_e        state_q;
   logic [LEN_W-1:0]  remain_q;
   logic [SIZE_W-1:0] size_eff;
   logic              take_cmd;
   logic              take_beat;

   assign size_eff  = (cmd_size > SIZE_CAP) ? SIZE_CAP : cmd_size;
   assign cmd_ready = (state_q == SEQ_IDLE);
   assign take_cmd  = cmd_valid && cmd_ready;
   assign beat_valid = (state_q == SEQ_BEAT);
   assign take_beat = beat_valid && beat_ready;
   assign is_last   = beat_valid && (remain_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         remain_q <= '0;
         cur_addr <= '0;
         cur_size <= '0;
      end else if (take_cmd) begin
         state_q  <= SEQ_BEAT;
         remain_q <= cmd_len;
         cur_addr <= cmd_addr;
         cur_size <= size_eff;
      end else if (take_beat) begin
         if (remain_q == '0) begin
            state_q <= SEQ_IDLE;
         end else begin
            remain_q <= remain_q - 1'b1;
            cur_addr <= cur_addr + (ADDR_W'(1) << cur_size);
         end
      end
   end
endmodule

// File: rtl/bstrb_lane_mask.sv
module bstrb_lane_mask #(
   parameter int LANES  = 8,
   parameter int SIZE_W = 3
) (
   input  logic [$clog2(LANES)-1:0] ofs,
   input  logic [SIZE_W-1:0]        size,
   output logic [LANES-1:0]         strb
);
   localparam int OFS_W = $clog2(LANES);
   localparam int SUM_W = OFS_W + 2;

   logic [SUM_W-1:0] width_b;
   logic [SUM_W-1:0] lo_b;
   logic [SUM_W-1:0] hi_b;

   assign width_b = SUM_W'(1) << size;
   assign lo_b    = SUM_W'(ofs);
   assign hi_b    = lo_b + width_b;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      assign strb[ln] = (SUM_W'(ln) >= lo_b) && (SUM_W'(ln) < hi_b);
   end
endmodule

// File: rtl/burst_strobe_gen.sv
module burst_strobe_gen #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8,
   parameter int SIZE_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic [ADDR_W-1:0]   cmd_addr,
   input  logic [SIZE_W-1:0]   cmd_size,
   input  logic [LEN_W-1:0]    cmd_len,
   output logic                beat_valid,
   input  logic                beat_ready,
   output logic [ADDR_W-1:0]   beat_addr,
   output logic [DATA_W/8-1:0] beat_strb,
   output logic                beat_last
);
   localparam int LANES    = DATA_W / 8;
   localparam int OFS_W    = $clog2(LANES);
   localparam int MAX_SIZE = OFS_W;

   if ((DATA_W % 8) != 0 || LANES < 2 || (1 << OFS_W) != LANES) begin : g_bad_width
      $error("burst_strobe_gen: DATA_W must be a power-of-two byte multiple of at least 16");
   end
   if (ADDR_W < OFS_W + 1) begin : g_bad_addr
      $error("burst_strobe_gen: ADDR_W too narrow for the lane offset");
   end
   if ((1 << SIZE_W) <= MAX_SIZE) begin : g_bad_size
      $error("burst_strobe_gen: SIZE_W cannot encode the full bus width");
   end

   logic [SIZE_W-1:0] cur_size;

   bstrb_sequencer #(
      .ADDR_W  (ADDR_W),
      .LEN_W   (LEN_W),
      .SIZE_W  (SIZE_W),
      .MAX_SIZE(MAX_SIZE)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_addr  (cmd_addr),
      .cmd_size  (cmd_size),
      .cmd_len   (cmd_len),
      .cmd_ready (cmd_ready),
      .beat_ready(beat_ready),
      .beat_valid(beat_valid),
      .cur_addr  (beat_addr),
      .cur_size  (cur_size),
      .is_last   (beat_last)
   );

   bstrb_lane_mask #(
      .LANES (LANES),
      .SIZE_W(SIZE_W)
   ) u_mask (
      .ofs (beat_addr[OFS_W-1:0]),
      .size(cur_size),
      .strb(beat_strb)
   );
endmodule

// File: rtl/bstrb_checker.sv
module bstrb_checker #(
   parameter int LANES  = 8,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              beat_valid,
   input logic              beat_ready,
   input logic [ADDR_W-1:0] beat_addr,
   input logic [LANES-1:0]  beat_strb,
   input logic              beat_last
);
   localparam int OFS_W = $clog2(LANES);

   // R2
   idle_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_ready && beat_valid));

   // R9
   first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> beat_valid);

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_ready) |=>
         (beat_valid && $stable(beat_addr) && $stable(beat_strb) && $stable(beat_last)));

   // R3
   last_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_ready && beat_last) |=> (cmd_ready && !beat_valid));

   // R4
   step_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_ready && !beat_last) |=>
         ($countones(beat_addr - $past(beat_addr)) == 1));

   // R5
   base_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> beat_strb[beat_addr[OFS_W-1:0]]);

   // R5
   below_base_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |->
         ((beat_strb & ((LANES'(1) << beat_addr[OFS_W-1:0]) - LANES'(1))) == '0));
endmodule

bind burst_strobe_gen bstrb_checker #(
   .LANES (DATA_W / 8),
   .ADDR_W(ADDR_W)
) u_bstrb_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .beat_valid(beat_valid),
   .beat_ready(beat_ready),
   .beat_addr (beat_addr),
   .beat_strb (beat_strb),
   .beat_last (beat_last)
);

// File: tb/burst_strobe_gen_bench.sv
module burst_strobe_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [31:0] cmd_addr = '0;
   logic [2:0]  cmd_size = '0;
   logic [7:0]  cmd_len = '0;
   logic        beat_valid;
   logic        beat_ready = 1'b1;
   logic [31:0] beat_addr;
   logic [7:0]  beat_strb;
   logic        beat_last;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5ns clk = ~clk;

   burst_strobe_gen u_burst_strobe_gen (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_len(cmd_len),
      .beat_valid(beat_valid), .beat_ready(beat_ready),
      .beat_addr(beat_addr), .beat_strb(beat_strb), .beat_last(beat_last)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_strb(input logic [31:0] a, input int sz);
      int w = 1 << ((sz > 3) ? 3 : sz);
      int o = int'(a % 8);
      logic [7:0] s = '0;
      for (int i = 0; i < 8; i++) s[i] = (i >= o) && (i < o + w);
      return s;
   endfunction

   task automatic run_cmd(input logic [31:0] a, input int sz, input int ln,
                          input bit stall, input bit intrude, input string areq);
      int eff = (sz > 3) ? 3 : sz;
      string sreq = (sz > 3) ? "R6" : "R5";
      chk(cmd_ready == 1'b1, "R3", "idle before command", 32'(cmd_ready), 1);
      cmd_addr = a; cmd_size = 3'(sz); cmd_len = 8'(ln); cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(beat_valid == 1'b1, "R9", "first beat valid", 32'(beat_valid), 1);
      for (int k = 0; k <= ln; k++) begin
         logic [31:0] ea = a + (32'(k) << eff);
         if (intrude && k < ln) begin
            cmd_addr = 32'hDEAD_BEE0; cmd_size = 3'd0; cmd_len = 8'd9; cmd_valid = 1'b1;
         end else begin
            cmd_valid = 1'b0;
         end
         chk(beat_valid == 1'b1, "R3", "beat valid", 32'(beat_valid), 1);
         chk(beat_addr == ea, areq, "beat address", beat_addr, ea);
         chk(beat_strb == exp_strb(ea, sz), sreq, "beat strobe", 32'(beat_strb), 32'(exp_strb(ea, sz)));
         chk(beat_last == (k == ln), "R3", "last flag", 32'(beat_last), 32'(k == ln));
         if (intrude)
            chk(cmd_ready == 1'b0, "R2", "ready while busy", 32'(cmd_ready), 0);
         if (stall && (k % 2 == 0)) begin
            beat_ready = 1'b0;
            @(negedge clk);
            chk(beat_valid && beat_addr == ea && beat_strb == exp_strb(ea, sz)
                && beat_last == (k == ln), "R7", "held under stall", beat_addr, ea);
            beat_ready = 1'b1;
         end
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      chk(beat_valid == 1'b0, "R3", "no extra beat", 32'(beat_valid), 0);
      chk(cmd_ready == 1'b1, "R3", "idle after last", 32'(cmd_ready), 1);
   endtask

   initial begin
      int n = 0;
      @(negedge clk);
      chk(beat_valid == 1'b0, "R1", "valid in reset", 32'(beat_valid), 0);
      chk(cmd_ready == 1'b1, "R1", "ready in reset", 32'(cmd_ready), 1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(beat_valid == 1'b0, "R1", "valid after reset", 32'(beat_valid), 0);
      // Examples named in R5: 0x78 then 0x80 then 0x78 for addr 3, size 2.
      run_cmd(32'h3, 2, 2, 1'b0, 1'b0, "R4");
      for (int off = 0; off < 8; off++)
         for (int sz = 0; sz < 8; sz++)
            for (int ln = 0; ln < 4; ln++) begin
               run_cmd(32'h1000_0000 + 32'(n * 64 + off), sz, ln,
                       (n % 3) == 0, (n % 5) == 1 && ln > 0, "R4");
               n++;
            end
      // R8: address wraps past the top of the space
      run_cmd(32'hFFFF_FFF9, 2, 3, 1'b1, 1'b0, "R8");
      run_cmd(32'hFFFF_FFF0, 7, 3, 1'b0, 1'b1, "R8");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1ms;
      if (!done) begin
         errors++;
         $display("FAIL R9 watchdog actual=hung expected=complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule